// File: doc/BRIEF.md
# Four-Stage Pipelined Integer Core

A 32-bit load/store processor core split into four pipeline stages: fetch, decode, execute and write-back, with a pipeline register between each adjacent pair. Fetch reads a read-only program array that is fixed by a parameter image. Decode holds a 32-entry register file with two read ports and one write port. Write-back contains the byte-addressable data RAM, so loads and stores touch memory in the last stage. The core runs a small integer subset of a classic three-format instruction set (register, immediate and jump forms).

Read-after-write dependences are handled without waiting wherever possible. An ALU result in execute is forwarded into decode's operand selection, and a value being written back is passed straight through to a decode read of the same register. A load whose result is needed by the very next instruction holds fetch and decode for one cycle. Branches and jumps resolve in decode and have exactly one architectural delay slot that always executes. Nothing is flushed.

The only ports are clock, synchronous reset and a set of debug outputs: the fetch address, the register write port, and the data memory write port.

Top module: `pipe4_core`

## Requirements
- R1: While `rst` is high, `dbg_pc` is 0 and neither `dbg_rf_we` nor `dbg_mem_we` is set. On the first edge after release the fetch address becomes 4, and it then advances by 4 each cycle unless it is redirected or held.
- R2: Opcode 0x00 with shamt 0 and funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or, or 0x2A signed set-less-than writes rd (bits 15:11) from rs (bits 25:21) and rt (bits 20:16).
- R3: Opcode 0x08 (add-immediate) writes rs plus the sign-extended imm[15:0] into rt. Opcode 0x18 (subtract-immediate) writes rs minus the sign-extended imm[15:0] into rt.
- R4: Register 0 always reads as zero, and a write to it is dropped and never shown on `dbg_rf_we`. The all-zero word (nop) writes nothing.
- R5: A result from the instruction in execute reaches the next instruction's operands in decode. A value being written in write-back is seen by a decode read of the same register in that same cycle.
- R6: An instruction directly after a load that reads the load's destination gets the loaded value. Fetch and decode are held for one cycle, and a bubble enters execute.
- R7: Opcode 0x23 loads the aligned big-endian word, in which the byte at offset 0 is bits 31:24. Opcode 0x24 loads the addressed byte zero-extended. Both write rt, and the address is rs plus the sign-extended immediate.
- R8: Opcode 0x2B stores rt to the aligned word with `dbg_mem_be`=1111. Opcode 0x28 stores rt[7:0] into the single lane `dbg_mem_be[3-offset]`, with `dbg_mem_wdata` holding that byte in all four lanes. `dbg_mem_addr` shows rs plus the sign-extended immediate.
- R9: Opcodes 0x04 (branch if equal) and 0x05 (branch if not equal) compare rs and rt in decode. The target is the delay-slot address plus the sign-extended immediate times 4. The delay slot always executes, and instructions that are branched over write nothing.
- R10: Opcode 0x02 (jump) and opcode 0x03 (jump-and-link) go to {delay-slot address[31:28], instr[25:0], 00}. Jump-and-link writes its own address plus 8 into register 31. Funct 0x08 under opcode 0x00 jumps to rs. Each of these has one delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address being fetched |
| dbg_rf_we | output | 1 | Register file write this cycle (never for register 0) |
| dbg_rf_waddr | output | 5 | Register being written |
| dbg_rf_wdata | output | 32 | Value being written |
| dbg_mem_we | output | 1 | Data RAM store this cycle |
| dbg_mem_be | output | 4 | Byte lanes written; bit 3 is bits 31:24 (offset 0) |
| dbg_mem_addr | output | 32 | Byte address of the store |
| dbg_mem_wdata | output | 32 | Store data as placed on the lanes |

## Verification
The program mixes independent operations, back-to-back dependent pairs and two-apart dependences. These separate the execute-to-decode forward path from the write-back pass-through and from a plain register file read. A load followed at once by an ALU consumer, and a load followed at once by a branch, exercise the one-cycle hold on both operand paths. Byte stores at offsets 1 and 3, followed by a word load and byte loads, expose any lane or endianness error. Taken and untaken branches, a jump, a link-and-return pair, and instructions placed only on skipped paths show whether delay slots run and whether skipped code stays silent. An instruction-level model in the bench computes the expected write stream.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
   localparam int XLEN   = 32;
   localparam int REG_AW = 5;
   localparam int NREGS  = 1 << REG_AW;
   localparam int LANES  = XLEN / 8;

   typedef logic [XLEN-1:0]   word_t;
   typedef logic [REG_AW-1:0] reg_idx_t;

   localparam logic [5:0] OP_SPECIAL = 6'h00;
   localparam logic [5:0] OP_J       = 6'h02;
   localparam logic [5:0] OP_JAL     = 6'h03;
   localparam logic [5:0] OP_BEQ     = 6'h04;
   localparam logic [5:0] OP_BNE     = 6'h05;
   localparam logic [5:0] OP_ADDI    = 6'h08;
   localparam logic [5:0] OP_SUBI    = 6'h18;
   localparam logic [5:0] OP_LW      = 6'h23;
   localparam logic [5:0] OP_LBU     = 6'h24;
   localparam logic [5:0] OP_SB      = 6'h28;
   localparam logic [5:0] OP_SW      = 6'h2B;

   localparam logic [5:0] FN_JR  = 6'h08;
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   localparam reg_idx_t LINK_REG = reg_idx_t'(NREGS - 1);

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_op_e;

   // decode -> execute register
   typedef struct packed {
      alu_op_e  alu_op;
      logic     wb_en;
      reg_idx_t dest;
      logic     mem_rd;
      logic     mem_wr;
      logic     mem_byte;
      word_t    op_a;
      word_t    op_b;
      word_t    st_data;
   } dx_t;

   // execute -> write-back register
   typedef struct packed {
      logic     wb_en;
      reg_idx_t dest;
      logic     mem_rd;
      logic     mem_wr;
      logic     mem_byte;
      word_t    result;
      word_t    st_data;
   } xw_t;
endpackage

// File: rtl/pipe4_fetch.sv
module pipe4_fetch
   import pipe4_pkg::*;
#(
   parameter int ROM_WORDS = 64,
   parameter logic [ROM_WORDS*XLEN-1:0] ROM_IMAGE = '0
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  hold,
   input  logic  redirect,
   input  word_t target,
   output word_t pc,
   output word_t fd_instr,
   output word_t fd_pc
);
   localparam int ROM_AW = $clog2(ROM_WORDS);

   if (ROM_WORDS < 2 || (ROM_WORDS & (ROM_WORDS - 1)) != 0) begin : g_bad_rom
      $error("ROM_WORDS must be a power of two of at least 2");
   end

   word_t rom [ROM_WORDS];
   for (genvar i = 0; i < ROM_WORDS; i++) begin : g_rom
      assign rom[i] = ROM_IMAGE[i*XLEN +: XLEN];
   end

   logic  in_range;
   word_t rom_word;

   assign in_range = (pc >> (ROM_AW + 2)) == '0;
   assign rom_word = in_range ? rom[pc[ROM_AW+1:2]] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc       <= '0;
         fd_instr <= '0;
         fd_pc    <= '0;
      end else if (!hold) begin
         pc       <= redirect ? target : pc + word_t'(4);
         fd_instr <= rom_word;
         fd_pc    <= pc;
      end
   end

   p_hold_keeps_pc_r6: assert property (@(posedge clk) disable iff (rst)
      hold |=> pc == $past(pc));
endmodule

// File: rtl/pipe4_decode.sv
module pipe4_decode
   import pipe4_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  word_t    fd_instr,
   input  word_t    fd_pc,
   input  word_t    ex_result,
   input  logic     wb_we,
   input  reg_idx_t wb_addr,
   input  word_t    wb_data,
   output logic     hold,
   output logic     redirect,
   output word_t    target,
   output dx_t      dx
);
   word_t rf [NREGS];

   logic [5:0] opcode, funct;
   logic [4:0] shamt;
   reg_idx_t   rs, rt, rd;
   logic [15:0] imm;
   word_t      simm, bofs, pc4;

   assign opcode = fd_instr[31:26];
   assign rs     = fd_instr[25:21];
   assign rt     = fd_instr[20:16];
   assign rd     = fd_instr[15:11];
   assign shamt  = fd_instr[10:6];
   assign funct  = fd_instr[5:0];
   assign imm    = fd_instr[15:0];
   assign simm   = {{(XLEN-16){imm[15]}}, imm};
   assign bofs   = {simm[XLEN-3:0], 2'b00};
   assign pc4    = fd_pc + word_t'(4);

   // register file write port (register 0 never stored)
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREGS; i++) rf[i] <= '0;
      end else if (wb_we && wb_addr != '0) begin
         rf[wb_addr] <= wb_data;
      end
   end

   // operand selection: execute forward beats write-back pass-through
   word_t rs_val, rt_val;
   always_comb begin
      rs_val = rf[rs];
      if (wb_we && wb_addr == rs && rs != '0) rs_val = wb_data;
      if (dx.wb_en && !dx.mem_rd && dx.dest == rs && rs != '0) rs_val = ex_result;
   end
   always_comb begin
      rt_val = rf[rt];
      if (wb_we && wb_addr == rt && rt != '0) rt_val = wb_data;
      if (dx.wb_en && !dx.mem_rd && dx.dest == rt && rt != '0) rt_val = ex_result;
   end

   dx_t   nx;
   logic  uses_rs, uses_rt, take;
   word_t tgt;

   always_comb begin
      nx      = '0;
      uses_rs = 1'b0;
      uses_rt = 1'b0;
      take    = 1'b0;
      tgt     = pc4;
      case (opcode)
         OP_SPECIAL: begin
            if (funct == FN_JR) begin
               uses_rs = 1'b1;
               take    = 1'b1;
               tgt     = rs_val;
            end else if (shamt == '0 && (funct == FN_ADD || funct == FN_SUB ||
                         funct == FN_AND || funct == FN_OR || funct == FN_SLT)) begin
               uses_rs  = 1'b1;
               uses_rt  = 1'b1;
               nx.wb_en = 1'b1;
               nx.dest  = rd;
               nx.op_a  = rs_val;
               nx.op_b  = rt_val;
               case (funct)
                  FN_SUB:  nx.alu_op = ALU_SUB;
                  FN_AND:  nx.alu_op = ALU_AND;
                  FN_OR:   nx.alu_op = ALU_OR;
                  FN_SLT:  nx.alu_op = ALU_SLT;
                  default: nx.alu_op = ALU_ADD;
               endcase
            end
         end
         OP_ADDI, OP_SUBI: begin
            uses_rs   = 1'b1;
            nx.wb_en  = 1'b1;
            nx.dest   = rt;
            nx.op_a   = rs_val;
            nx.op_b   = simm;
            nx.alu_op = (opcode == OP_SUBI) ? ALU_SUB : ALU_ADD;
         end
         OP_LW, OP_LBU: begin
            uses_rs     = 1'b1;
            nx.wb_en    = 1'b1;
            nx.dest     = rt;
            nx.mem_rd   = 1'b1;
            nx.mem_byte = (opcode == OP_LBU);
            nx.op_a     = rs_val;
            nx.op_b     = simm;
         end
         OP_SW, OP_SB: begin
            uses_rs     = 1'b1;
            uses_rt     = 1'b1;
            nx.mem_wr   = 1'b1;
            nx.mem_byte = (opcode == OP_SB);
            nx.op_a     = rs_val;
            nx.op_b     = simm;
            nx.st_data  = rt_val;
         end
         OP_BEQ, OP_BNE: begin
            uses_rs = 1'b1;
            uses_rt = 1'b1;
            take    = (rs_val == rt_val) ^ (opcode == OP_BNE);
            tgt     = pc4 + bofs;
         end
         OP_J, OP_JAL: begin
            take = 1'b1;
            tgt  = {pc4[XLEN-1:28], fd_instr[25:0], 2'b00};
            if (opcode == OP_JAL) begin
               nx.wb_en = 1'b1;
               nx.dest  = LINK_REG;
               nx.op_a  = fd_pc + word_t'(8);
               nx.op_b  = '0;
            end
         end
         default: ;
      endcase
   end

   // a load still in execute cannot be forwarded: hold one cycle
   logic load_hazard;
   assign load_hazard = dx.mem_rd && dx.dest != '0 &&
                        ((uses_rs && rs == dx.dest) || (uses_rt && rt == dx.dest));

   assign hold     = load_hazard;
   assign redirect = take && !load_hazard;
   assign target   = tgt;

   always_ff @(posedge clk) begin
      if (rst || load_hazard) dx <= '0;
      else                    dx <= nx;
   end

   p_zero_reg_r4: assert property (@(posedge clk) disable iff (rst)
      rf[0] == '0);

   p_stall_bubble_r6: assert property (@(posedge clk) disable iff (rst)
      hold |=> (!dx.wb_en && !dx.mem_wr && !dx.mem_rd));
endmodule

// File: rtl/pipe4_execute.sv
module pipe4_execute
   import pipe4_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  dx_t   dx,
   output word_t ex_result,
   output xw_t   xw
);
   always_comb begin
      case (dx.alu_op)
         ALU_SUB: ex_result = dx.op_a - dx.op_b;
         ALU_AND: ex_result = dx.op_a & dx.op_b;
         ALU_OR:  ex_result = dx.op_a | dx.op_b;
         ALU_SLT: ex_result = {{(XLEN-1){1'b0}}, ($signed(dx.op_a) < $signed(dx.op_b))};
         default: ex_result = dx.op_a + dx.op_b;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         xw <= '0;
      end else begin
         xw.wb_en    <= dx.wb_en;
         xw.dest     <= dx.dest;
         xw.mem_rd   <= dx.mem_rd;
         xw.mem_wr   <= dx.mem_wr;
         xw.mem_byte <= dx.mem_byte;
         xw.result   <= ex_result;
         xw.st_data  <= dx.st_data;
      end
   end

   p_no_write_and_store_r8: assert property (@(posedge clk) disable iff (rst)
      !(xw.mem_wr && xw.wb_en));
endmodule

// File: rtl/pipe4_writeback.sv
module pipe4_writeback
   import pipe4_pkg::*;
#(
   parameter int RAM_WORDS = 64
) (
   input  logic       clk,
   input  logic       rst,
   input  xw_t        xw,
   output logic       wb_we,
   output reg_idx_t   wb_addr,
   output word_t      wb_data,
   output logic       st_we,
   output logic [LANES-1:0] st_be,
   output word_t      st_addr,
   output word_t      st_wdata
);
   localparam int RAM_AW = $clog2(RAM_WORDS);

   if (RAM_WORDS < 2 || (RAM_WORDS & (RAM_WORDS - 1)) != 0) begin : g_bad_ram
      $error("RAM_WORDS must be a power of two of at least 2");
   end

   logic              in_range;
   logic [RAM_AW-1:0] widx;
   logic [1:0]        offs;
   logic [LANES-1:0]  be;
   word_t             lane_data;
   logic [LANES-1:0][7:0] rd_bytes;

   assign in_range  = (xw.result >> (RAM_AW + 2)) == '0;
   assign widx      = xw.result[RAM_AW+1:2];
   assign offs      = xw.result[1:0];
   // big-endian: offset 0 lives in the top lane
   assign be        = xw.mem_byte ? (LANES'(1) << (LANES - 1 - int'(offs))) : '1;
   assign lane_data = xw.mem_byte ? {LANES{xw.st_data[7:0]}} : xw.st_data;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_mem [RAM_WORDS];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int w = 0; w < RAM_WORDS; w++) lane_mem[w] <= '0;
         end else if (xw.mem_wr && in_range && be[l]) begin
            lane_mem[widx] <= lane_data[8*l +: 8];
         end
      end
      assign rd_bytes[l] = in_range ? lane_mem[widx] : 8'h00;
   end

   word_t ld_word;
   logic [7:0] ld_byte;
   assign ld_word = rd_bytes;
   assign ld_byte = rd_bytes[~offs];

   assign wb_we   = xw.wb_en && xw.dest != '0;
   assign wb_addr = xw.dest;
   assign wb_data = !xw.mem_rd  ? xw.result :
                    xw.mem_byte ? {{(XLEN-8){1'b0}}, ld_byte} : ld_word;

   assign st_we    = xw.mem_wr;
   assign st_be    = xw.mem_wr ? be : '0;
   assign st_addr  = xw.result;
   assign st_wdata = lane_data;

   p_lane_shape_r8: assert property (@(posedge clk) disable iff (rst)
      st_we |-> (st_be == '1 || $countones(st_be) == 1));

   p_no_zero_write_r4: assert property (@(posedge clk) disable iff (rst)
      wb_we |-> wb_addr != '0);

   p_byte_load_zext_r7: assert property (@(posedge clk) disable iff (rst)
      (wb_we && xw.mem_rd && xw.mem_byte) |-> wb_data[XLEN-1:8] == '0);
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
   import pipe4_pkg::*;
#(
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter logic [IMEM_WORDS*32-1:0] PROG_IMAGE = '0
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] dbg_pc,
   output logic        dbg_rf_we,
   output logic [4:0]  dbg_rf_waddr,
   output logic [31:0] dbg_rf_wdata,
   output logic        dbg_mem_we,
   output logic [3:0]  dbg_mem_be,
   output logic [31:0] dbg_mem_addr,
   output logic [31:0] dbg_mem_wdata
);
   if (XLEN != 32) begin : g_bad_width
      $error("core is built for a 32-bit word");
   end

   logic     hold, redirect;
   word_t    target, pc, fd_instr, fd_pc, ex_result;
   dx_t      dx;
   xw_t      xw;
   logic     wb_we;
   reg_idx_t wb_addr;
   word_t    wb_data;

   pipe4_fetch #(
      .ROM_WORDS (IMEM_WORDS),
      .ROM_IMAGE (PROG_IMAGE)
   ) u_fetch (
      .clk      (clk),
      .rst      (rst),
      .hold     (hold),
      .redirect (redirect),
      .target   (target),
      .pc       (pc),
      .fd_instr (fd_instr),
      .fd_pc    (fd_pc)
   );

   pipe4_decode u_decode (
      .clk       (clk),
      .rst       (rst),
      .fd_instr  (fd_instr),
      .fd_pc     (fd_pc),
      .ex_result (ex_result),
      .wb_we     (wb_we),
      .wb_addr   (wb_addr),
      .wb_data   (wb_data),
      .hold      (hold),
      .redirect  (redirect),
      .target    (target),
      .dx        (dx)
   );

   pipe4_execute u_execute (
      .clk       (clk),
      .rst       (rst),
      .dx        (dx),
      .ex_result (ex_result),
      .xw        (xw)
   );

   pipe4_writeback #(
      .RAM_WORDS (DMEM_WORDS)
   ) u_writeback (
      .clk      (clk),
      .rst      (rst),
      .xw       (xw),
      .wb_we    (wb_we),
      .wb_addr  (wb_addr),
      .wb_data  (wb_data),
      .st_we    (dbg_mem_we),
      .st_be    (dbg_mem_be),
      .st_addr  (dbg_mem_addr),
      .st_wdata (dbg_mem_wdata)
   );

   assign dbg_pc       = pc;
   assign dbg_rf_we    = wb_we;
   assign dbg_rf_waddr = wb_addr;
   assign dbg_rf_wdata = wb_data;

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (dbg_pc == '0 && !dbg_rf_we && !dbg_mem_we));
endmodule

// File: tb/test_pipe4_core.sv
`timescale 1ns/1ps
module test_pipe4_core;
   localparam int IW = 64;
   localparam int END_PC = 40 * 4;

   function automatic logic [31:0] r_ins(int fn, int rd, int rs, int rt);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'h00, fn[5:0]};
   endfunction
   function automatic logic [31:0] i_ins(int op, int rt, int rs, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] j_ins(int op, int widx);
      return {op[5:0], widx[25:0]};
   endfunction

   function automatic logic [IW*32-1:0] build_prog();
      logic [IW*32-1:0] p;
      p = '0;
      p[32*0  +: 32] = i_ins(8'h08, 1, 0, 5);
      p[32*1  +: 32] = i_ins(8'h08, 2, 0, -3);
      p[32*2  +: 32] = r_ins(8'h20, 3, 1, 2);
      p[32*3  +: 32] = r_ins(8'h22, 4, 3, 1);
      p[32*4  +: 32] = r_ins(8'h24, 5, 1, 2);
      p[32*5  +: 32] = r_ins(8'h25, 6, 3, 4);
      p[32*6  +: 32] = r_ins(8'h2A, 7, 2, 1);
      p[32*7  +: 32] = r_ins(8'h2A, 8, 1, 2);
      p[32*8  +: 32] = i_ins(8'h18, 9, 1, 7);
      p[32*9  +: 32] = i_ins(8'h08, 0, 1, 1);
      p[32*10 +: 32] = r_ins(8'h20, 10, 0, 1);
      p[32*11 +: 32] = i_ins(8'h08, 11, 0, 16'h1234);
      p[32*12 +: 32] = i_ins(8'h2B, 11, 0, 8);
      p[32*13 +: 32] = i_ins(8'h28, 1, 0, 9);
      p[32*14 +: 32] = i_ins(8'h23, 14, 0, 8);
      p[32*15 +: 32] = r_ins(8'h20, 15, 14, 1);
      p[32*16 +: 32] = i_ins(8'h24, 16, 0, 9);
      p[32*17 +: 32] = i_ins(8'h28, 6, 0, 11);
      p[32*18 +: 32] = i_ins(8'h24, 17, 0, 11);
      p[32*19 +: 32] = i_ins(8'h24, 18, 0, 10);
      p[32*20 +: 32] = i_ins(8'h04, 10, 1, 2);
      p[32*21 +: 32] = i_ins(8'h08, 19, 0, 1);
      p[32*22 +: 32] = i_ins(8'h08, 20, 0, 99);
      p[32*23 +: 32] = i_ins(8'h05, 1, 1, 5);
      p[32*24 +: 32] = i_ins(8'h08, 21, 0, 2);
      p[32*25 +: 32] = i_ins(8'h05, 0, 17, 1);
      p[32*26 +: 32] = i_ins(8'h08, 22, 0, 3);
      p[32*27 +: 32] = j_ins(8'h03, 32);
      p[32*28 +: 32] = i_ins(8'h08, 23, 0, 4);
      p[32*29 +: 32] = i_ins(8'h08, 25, 0, 7);
      p[32*30 +: 32] = j_ins(8'h02, 36);
      p[32*31 +: 32] = i_ins(8'h08, 26, 0, 8);
      p[32*32 +: 32] = i_ins(8'h08, 24, 0, 6);
      p[32*33 +: 32] = r_ins(8'h08, 0, 31, 0);
      p[32*34 +: 32] = i_ins(8'h08, 27, 0, 9);
      p[32*35 +: 32] = i_ins(8'h08, 28, 0, 1);
      p[32*36 +: 32] = i_ins(8'h23, 29, 0, 8);
      p[32*37 +: 32] = i_ins(8'h05, 0, 29, 2);
      p[32*38 +: 32] = i_ins(8'h08, 30, 0, 5);
      p[32*39 +: 32] = i_ins(8'h08, 28, 0, 77);
      p[32*40 +: 32] = j_ins(8'h02, 40);
      return p;
   endfunction

   localparam logic [IW*32-1:0] PROG = build_prog();

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] dbg_pc, dbg_rf_wdata, dbg_mem_addr, dbg_mem_wdata;
   logic        dbg_rf_we, dbg_mem_we;
   logic [4:0]  dbg_rf_waddr;
   logic [3:0]  dbg_mem_be;

   always #4 clk = ~clk;

   pipe4_core #(
      .IMEM_WORDS (IW),
      .DMEM_WORDS (64),
      .PROG_IMAGE (PROG)
   ) i_pipe4_core (
      .clk           (clk),
      .rst           (rst),
      .dbg_pc        (dbg_pc),
      .dbg_rf_we     (dbg_rf_we),
      .dbg_rf_waddr  (dbg_rf_waddr),
      .dbg_rf_wdata  (dbg_rf_wdata),
      .dbg_mem_we    (dbg_mem_we),
      .dbg_mem_be    (dbg_mem_be),
      .dbg_mem_addr  (dbg_mem_addr),
      .dbg_mem_wdata (dbg_mem_wdata)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   typedef struct { int tag; logic [4:0] a; logic [31:0] d; } rexp_t;
   typedef struct { int tag; logic [31:0] addr; logic [3:0] be; logic [31:0] d; } mexp_t;
   rexp_t rq[$];
   mexp_t mq[$];

   function automatic string tname(int t);
      case (t)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   5: return "R5";   6: return "R6";
         7: return "R7";   8: return "R8";   9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: instruction-level model pushes the expected write stream
   task automatic run_model();
      logic [31:0] rg [32];
      logic [7:0]  mb [256];
      logic [31:0] pc, npc, nn, ins, a, b, simm, val, addr;
      logic [5:0]  op, fn;
      int rs, rt, rd, dst, tag, prev_dest, prev_ctl;
      bit wr, prev_load, r_rs, r_rt;
      for (int i = 0; i < 32; i++) rg[i] = '0;
      for (int i = 0; i < 256; i++) mb[i] = '0;
      pc = 0; npc = 4; prev_dest = -1; prev_ctl = 0; prev_load = 0;
      for (int step = 0; step < 200 && pc != END_PC; step++) begin
         ins  = PROG[32*int'(pc[7:2]) +: 32];
         op   = ins[31:26]; fn = ins[5:0];
         rs   = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
         a    = rg[rs]; b = rg[rt];
         simm = {{16{ins[15]}}, ins[15:0]};
         nn   = npc + 4;
         wr = 0; dst = 0; val = '0; tag = 3; r_rs = 1; r_rt = 0;
         case (op)
            6'h00: begin
               r_rt = (fn != 6'h08);
               if (fn == 6'h08) nn = a;
               else begin
                  wr = (ins != 0); dst = rd; tag = 2;
                  case (fn)
                     6'h20: val = a + b;
                     6'h22: val = a - b;
                     6'h24: val = a & b;
                     6'h25: val = a | b;
                     6'h2A: val = {31'b0, $signed(a) < $signed(b)};
                     default: wr = 0;
                  endcase
                  if (rs == 0 || rt == 0) tag = 4;
               end
            end
            6'h08: begin wr = 1; dst = rt; val = a + simm; end
            6'h18: begin wr = 1; dst = rt; val = a - simm; end
            6'h23: begin
               addr = a + simm; wr = 1; dst = rt; tag = 7;
               val = {mb[addr[7:0]], mb[addr[7:0]+1], mb[addr[7:0]+2], mb[addr[7:0]+3]};
            end
            6'h24: begin addr = a + simm; wr = 1; dst = rt; tag = 7; val = {24'b0, mb[addr[7:0]]}; end
            6'h2B: begin
               addr = a + simm; r_rt = 1;
               {mb[addr[7:0]], mb[addr[7:0]+1], mb[addr[7:0]+2], mb[addr[7:0]+3]} = b;
               mq.push_back('{tag: 8, addr: addr, be: 4'b1111, d: b});
            end
            6'h28: begin
               addr = a + simm; r_rt = 1; mb[addr[7:0]] = b[7:0];
               mq.push_back('{tag: 8, addr: addr, be: 4'b1000 >> addr[1:0], d: {4{b[7:0]}}});
            end
            6'h04: begin r_rt = 1; if (a == b) nn = npc + {simm[29:0], 2'b00}; end
            6'h05: begin r_rt = 1; if (a != b) nn = npc + {simm[29:0], 2'b00}; end
            6'h02: begin r_rs = 0; nn = {npc[31:28], ins[25:0], 2'b00}; end
            6'h03: begin
               r_rs = 0; nn = {npc[31:28], ins[25:0], 2'b00};
               wr = 1; dst = 31; val = pc + 8; tag = 10;
            end
            default: r_rs = 0;
         endcase
         if (prev_dest > 0 && ((r_rs && rs == prev_dest) || (r_rt && rt == prev_dest)))
            tag = prev_load ? 6 : 5;
         if (prev_ctl != 0) tag = prev_ctl;
         if (wr && dst != 0) begin
            rg[dst] = val;
            rq.push_back('{tag: tag, a: dst[4:0], d: val});
         end
         prev_dest = (wr && dst != 0) ? dst : -1;
         prev_load = (op == 6'h23 || op == 6'h24);
         prev_ctl  = (op == 6'h04 || op == 6'h05) ? 9 :
                     (op == 6'h02 || op == 6'h03 || (op == 6'h00 && fn == 6'h08)) ? 10 : 0;
         pc = npc; npc = nn;
      end
   endtask

   // monitor: compare write-back and store events as they appear
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (dbg_rf_we) begin
            if (rq.size() == 0) begin
               chk("R9", 1'b0, {27'b0, dbg_rf_waddr, dbg_rf_wdata}, '0);
            end else begin
               rexp_t e;
               e = rq.pop_front();
               chk(tname(e.tag), dbg_rf_waddr == e.a && dbg_rf_wdata == e.d,
                   {27'b0, dbg_rf_waddr, dbg_rf_wdata}, {27'b0, e.a, e.d});
            end
         end
         if (dbg_mem_we) begin
            if (mq.size() == 0) begin
               chk("R8", 1'b0, {dbg_mem_addr, dbg_mem_wdata}, '0);
            end else begin
               mexp_t m;
               m = mq.pop_front();
               chk(tname(m.tag), dbg_mem_addr == m.addr && dbg_mem_wdata == m.d,
                   {dbg_mem_addr, dbg_mem_wdata}, {m.addr, m.d});
               chk("R8", dbg_mem_be == m.be, {60'b0, dbg_mem_be}, {60'b0, m.be});
            end
         end
      end
   end

   initial begin
      run_model();
      repeat (3) @(negedge clk);
      // R1: quiet reset state
      chk("R1", dbg_pc == 0 && !dbg_rf_we && !dbg_mem_we,
          {31'b0, dbg_rf_we, dbg_pc}, '0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", dbg_pc == 32'd4, {32'b0, dbg_pc}, 64'd4);
      repeat (150) @(negedge clk);
      // R9/R10 side: every expected write seen, none extra
      chk("R9", rq.size() == 0, 64'(rq.size()), 0);
      chk("R8", mq.size() == 0, 64'(mq.size()), 0);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL R1 watchdog actual=expired expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end
endmodule